// File: doc/BRIEF.md
# Predicated Dock Move Executor

This block runs move instructions at one dock of a data fabric. Instructions are 25 bits wide. Each one is either held for execution or discarded, depending on a predicate flag P and the instruction's unconditional bit. A held move names the handshakes it needs: take a word from the fabric, transfer with the ship, capture the incoming word into a data latch, or put the latched word onto the fabric. It may also decrement the loop counter LC and repeat itself. A pending kill request, called a torpedo, abandons any waiting move that is not marked immune. The parameter `INPUT_DOCK` sets the ship direction. When it is 0 (output dock), the ship supplies words. When it is 1 (input dock), the dock hands words to the ship.

Every data channel is valid/ready, and a word moves on a clock edge where both are high. The fabric output and the ship output are one-entry slots. Once filled, valid stays high and the data does not change until ready is seen. Back-pressure on the fabric slot stalls every later move, because a move may start only while that slot is empty. The block raises `fin_ready` and `ship_in_ready` only in the cycle it takes a word. Upstream may hold its valid high for as long as it wants.

Top module: `dock_move_exec`

## Requirements
- R1: `instr_ready` is high exactly when no move is held, and it is high after reset. A word is taken on an edge with `instr_valid` and `instr_ready` both high. After reset P=0, LC=0 and `fout_valid`=0.
- R2: Bit 24 is the unconditional bit. When it is 1, the move executes whatever the value of P. When it is 0 and P is 0, the move is discarded and has no handshake, no counter change and no output.
- R3: Bit 21 must be 0 for a move. A word with bit 21 set is taken and discarded with no effect.
- R4: Bit 17 (fabric in) makes the move wait for `fin_valid`. The move then takes exactly one word, with `fin_ready` high for one cycle.
- R5: Bit 14 (fabric out) fills the fabric output slot. That slot keeps valid and data steady until `fout_ready`. No move fires while the slot is full, and words leave in issue order.
- R6: Bit 16 (ship) makes the move wait on the ship side. At an output dock it waits for `ship_in_valid` and takes one ship word. At an input dock it waits for the ship output slot to be empty and then fills it.
- R7: Bit 15 (capture) loads the data latch. The source is the fabric word when bit 17 is set and the ship word otherwise. Outgoing words carry the latch value, including any capture made by the same move. Without bit 15 the latch keeps its value.
- R8: Bit 18 (decrement) subtracts one from LC on each execution. LC does not go below zero, and a decrement at zero leaves P unchanged. A decrement from 1 to 0 clears P.
- R9: `flag_z` is high exactly when LC is zero.
- R10: Bit 20 (repeat) keeps the move held and firing again. It stops when the predicate fails: bit 24 clear and P=0. With bit 24 set and bit 18 clear, the move stands until a torpedo removes it.
- R11: A `torpedo` pulse stays pending until used. A pending torpedo removes a held move with bit 19 (immune) clear, even when the move could fire. Removing the move uses up the torpedo and clears P. Immune moves run normally and leave the torpedo pending.
- R12: `set_p_en` writes `set_p_val` to P and takes priority over every clear of P. `lc_load_en` loads LC and takes priority over a decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | No move held; instruction can be taken |
| instr_word | input | 25 | Instruction word |
| fin_valid | input | 1 | Fabric predecessor holds a word |
| fin_ready | output | 1 | Fabric word taken this cycle |
| fin_data | input | DATA_W | Fabric incoming word |
| fout_valid | output | 1 | Fabric output slot full |
| fout_ready | input | 1 | Fabric successor accepts |
| fout_data | output | DATA_W | Fabric outgoing word |
| ship_in_valid | input | 1 | Ship offers a word (output dock) |
| ship_in_ready | output | 1 | Ship word taken this cycle |
| ship_in_data | input | DATA_W | Ship incoming word |
| ship_out_valid | output | 1 | Ship output slot full (input dock) |
| ship_out_ready | input | 1 | Ship accepts |
| ship_out_data | output | DATA_W | Word handed to the ship |
| torpedo | input | 1 | Kill request pulse |
| set_p_en | input | 1 | Write P |
| set_p_val | input | 1 | Value written to P |
| lc_load_en | input | 1 | Load LC |
| lc_load_val | input | LC_W | Value loaded into LC |
| flag_p | output | 1 | Predicate flag |
| flag_z | output | 1 | LC is zero |
| lc_value | output | LC_W | Loop counter |

## Verification
Two cases are hard to reach from the ports. The first is a software write of P that lands on the same edge as the counter's step from 1 to 0. The second is a torpedo that arrives while an immune move waits and is then used up by the next move. For the first, the bench holds `set_p_en` high for the whole run of an unconditional repeating decrement, so the collision always falls inside the window. For the second, it parks an immune move by holding `fin_valid` low, pulses the torpedo, lets the move finish, and then issues a non-immune move that must die without taking a word. A further non-immune move follows to show the torpedo has been used up.

// File: rtl/dock_move_pkg.sv
package dock_move_pkg;
  localparam int INSN_W   = 25;
  // Field positions that the sequencer decodes.
  localparam int BIT_U    = 24;
  localparam int BIT_KIND = 21;
  localparam int BIT_RPT  = 20;
  localparam int BIT_IMM  = 19;
  localparam int BIT_DEC  = 18;
  localparam int BIT_FIN  = 17;
  localparam int BIT_SHIP = 16;
  localparam int BIT_CAP  = 15;
  localparam int BIT_FOUT = 14;

  typedef struct packed {
    logic uncond;
    logic is_move;
    logic rpt;
    logic imm;
    logic dec;
    logic fin;
    logic ship;
    logic cap;
    logic fout;
  } move_ctl_t;

  typedef enum logic [1:0] {ACT_IDLE, ACT_DROP, ACT_KILL, ACT_FIRE} move_act_e;

  function automatic move_ctl_t decode_move(input logic [INSN_W-1:0] w);
    move_ctl_t c;
    c.uncond  = w[BIT_U];
    c.is_move = ~w[BIT_KIND];
    c.rpt     = w[BIT_RPT];
    c.imm     = w[BIT_IMM];
    c.dec     = w[BIT_DEC];
    c.fin     = w[BIT_FIN];
    c.ship    = w[BIT_SHIP];
    c.cap     = w[BIT_CAP];
    c.fout    = w[BIT_FOUT];
    return c;
  endfunction
endpackage

// File: rtl/dock_move_slot.sv
// One-entry output register with valid/ready draining.
module dock_move_slot #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // The sequencer may fill the slot only while it is empty.
  assert_fill_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !out_valid);
  // A word waiting for the consumer does not change.
  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !load) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/dock_move_flags.sv
// Predicate flag, loop counter and zero flag.
module dock_move_flags #(
  parameter int LC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dec,
  input  logic            kill,
  input  logic            set_en,
  input  logic            set_val,
  input  logic            load_en,
  input  logic [LC_W-1:0] load_val,
  output logic            p,
  output logic [LC_W-1:0] lc,
  output logic            z
);
  localparam logic [LC_W-1:0] LC_ONE = {{(LC_W-1){1'b0}}, 1'b1};

  logic do_step, hit_zero;

  assign do_step  = dec && !load_en && (lc != '0);
  assign hit_zero = do_step && (lc == LC_ONE);
  assign z        = (lc == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lc <= '0;
      p  <= 1'b0;
    end else begin
      if (load_en)      lc <= load_val;
      else if (do_step) lc <= lc - LC_ONE;

      if (set_en)                p <= set_val;
      else if (kill || hit_zero) p <= 1'b0;
    end
  end

  assert_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load_en && lc == '0 && !set_en && !kill) |=> (lc == '0 && $stable(p)));
  assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load_en && lc != '0) |=> (lc == $past(lc) - LC_ONE));
  assert_zero_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load_en && lc == LC_ONE && !set_en) |=> !p);
  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (p == $past(set_val)));
  assert_load_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (lc == $past(load_val)));
endmodule

// File: rtl/dock_move_seq.sv
// Holds one move and decides each cycle: discard, kill, fire or wait.
module dock_move_seq
  import dock_move_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] in_word,
  output logic              in_ready,
  input  logic              p_flag,
  input  logic              tp_pend,
  input  logic              fin_ok,
  input  logic              ship_ok,
  input  logic              fout_empty,
  output move_act_e         act,
  output logic              cur_fin,
  output logic              cur_ship,
  output logic              cur_cap,
  output logic              cur_fout,
  output logic              cur_dec,
  output logic              cur_rpt
);
  logic      busy_q;
  move_ctl_t ctl_q;
  logic      retire;

  always_comb begin
    act = ACT_IDLE;
    if (busy_q) begin
      if (!ctl_q.is_move || (!ctl_q.uncond && !p_flag))
        act = ACT_DROP;
      else if (!ctl_q.imm && tp_pend)
        act = ACT_KILL;
      else if (fout_empty && (!ctl_q.fin || fin_ok) && (!ctl_q.ship || ship_ok))
        act = ACT_FIRE;
    end
  end

  assign retire   = (act == ACT_DROP) || (act == ACT_KILL) ||
                    ((act == ACT_FIRE) && !ctl_q.rpt);
  assign in_ready = !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ctl_q  <= '0;
    end else if (in_valid && in_ready) begin
      busy_q <= 1'b1;
      ctl_q  <= decode_move(in_word);
    end else if (retire) begin
      busy_q <= 1'b0;
    end
  end

  assign cur_fin  = ctl_q.fin;
  assign cur_ship = ctl_q.ship;
  assign cur_cap  = ctl_q.cap;
  assign cur_fout = ctl_q.fout;
  assign cur_dec  = ctl_q.dec;
  assign cur_rpt  = ctl_q.rpt;

  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
endmodule

// File: rtl/dock_move_exec.sv
module dock_move_exec
  import dock_move_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LC_W       = 16,
  parameter bit INPUT_DOCK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic [INSN_W-1:0] instr_word,
  input  logic              fin_valid,
  output logic              fin_ready,
  input  logic [DATA_W-1:0] fin_data,
  output logic              fout_valid,
  input  logic              fout_ready,
  output logic [DATA_W-1:0] fout_data,
  input  logic              ship_in_valid,
  output logic              ship_in_ready,
  input  logic [DATA_W-1:0] ship_in_data,
  output logic              ship_out_valid,
  input  logic              ship_out_ready,
  output logic [DATA_W-1:0] ship_out_data,
  input  logic              torpedo,
  input  logic              set_p_en,
  input  logic              set_p_val,
  input  logic              lc_load_en,
  input  logic [LC_W-1:0]   lc_load_val,
  output logic              flag_p,
  output logic              flag_z,
  output logic [LC_W-1:0]   lc_value
);
  move_act_e         act;
  logic              fire, kill, tp_pend, ship_ok;
  logic              cur_fin, cur_ship, cur_cap, cur_fout, cur_dec, cur_rpt;
  logic [DATA_W-1:0] latch_q, in_sel, out_word;

  assign fire     = (act == ACT_FIRE);
  assign kill     = (act == ACT_KILL);
  assign in_sel   = cur_fin ? fin_data : ship_in_data;
  assign out_word = cur_cap ? in_sel : latch_q;
  assign fin_ready = fire && cur_fin;

  dock_move_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (instr_valid),
    .in_word    (instr_word),
    .in_ready   (instr_ready),
    .p_flag     (flag_p),
    .tp_pend    (tp_pend),
    .fin_ok     (fin_valid),
    .ship_ok    (ship_ok),
    .fout_empty (!fout_valid),
    .act        (act),
    .cur_fin    (cur_fin),
    .cur_ship   (cur_ship),
    .cur_cap    (cur_cap),
    .cur_fout   (cur_fout),
    .cur_dec    (cur_dec),
    .cur_rpt    (cur_rpt)
  );

  dock_move_flags #(.LC_W(LC_W)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec      (fire && cur_dec),
    .kill     (kill),
    .set_en   (set_p_en),
    .set_val  (set_p_val),
    .load_en  (lc_load_en),
    .load_val (lc_load_val),
    .p        (flag_p),
    .lc       (lc_value),
    .z        (flag_z)
  );

  dock_move_slot #(.DATA_W(DATA_W)) u_fout (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fire && cur_fout),
    .load_data (out_word),
    .out_valid (fout_valid),
    .out_ready (fout_ready),
    .out_data  (fout_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      tp_pend <= 1'b0;
    end else begin
      if (fire && cur_cap) latch_q <= in_sel;
      tp_pend <= (tp_pend && !kill) || torpedo;
    end
  end

  generate
    if (INPUT_DOCK) begin : g_input_dock
      dock_move_slot #(.DATA_W(DATA_W)) u_ship (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (fire && cur_ship),
        .load_data (out_word),
        .out_valid (ship_out_valid),
        .out_ready (ship_out_ready),
        .out_data  (ship_out_data)
      );
      assign ship_ok       = !ship_out_valid;
      assign ship_in_ready = 1'b0;
      logic unused_ship_in;
      assign unused_ship_in = ship_in_valid;
    end else begin : g_output_dock
      assign ship_ok        = ship_in_valid;
      assign ship_in_ready  = fire && cur_ship;
      assign ship_out_valid = 1'b0;
      assign ship_out_data  = '0;
      logic unused_ship_out;
      assign unused_ship_out = ship_out_ready;
    end
  endgenerate

  // A torpedo removal clears P unless software writes P in the same cycle.
  assert_kill_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (kill && !set_p_en) |=> !flag_p);
  // A repeating move stays held after it fires.
  assert_repeat_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cur_rpt) |=> !instr_ready);
  // A fabric word is taken only while one is offered.
  assert_fin_offered_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fin_ready |-> fin_valid);
endmodule

// File: tb/dock_move_exec_test.sv
module dock_move_exec_test;
  localparam int DW = 32;
  localparam int LW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          instr_valid = 0, instr_ready;
  logic [24:0]   instr_word = '0;
  logic          fin_valid = 0, fin_ready;
  logic [DW-1:0] fin_data = '0;
  logic          fout_valid, fout_ready = 1;
  logic [DW-1:0] fout_data;
  logic          ship_in_valid = 0, ship_in_ready;
  logic [DW-1:0] ship_in_data = '0;
  logic          ship_out_valid, ship_out_ready = 1;
  logic [DW-1:0] ship_out_data;
  logic          torpedo = 0, set_p_en = 0, set_p_val = 0, lc_load_en = 0;
  logic [LW-1:0] lc_load_val = '0;
  logic          flag_p, flag_z;
  logic [LW-1:0] lc_value;

  dock_move_exec #(.DATA_W(DW), .LC_W(LW), .INPUT_DOCK(1'b0)) uut (
    .clk(clk), .rst_n(rst_n),
    .instr_valid(instr_valid), .instr_ready(instr_ready), .instr_word(instr_word),
    .fin_valid(fin_valid), .fin_ready(fin_ready), .fin_data(fin_data),
    .fout_valid(fout_valid), .fout_ready(fout_ready), .fout_data(fout_data),
    .ship_in_valid(ship_in_valid), .ship_in_ready(ship_in_ready), .ship_in_data(ship_in_data),
    .ship_out_valid(ship_out_valid), .ship_out_ready(ship_out_ready), .ship_out_data(ship_out_data),
    .torpedo(torpedo), .set_p_en(set_p_en), .set_p_val(set_p_val),
    .lc_load_en(lc_load_en), .lc_load_val(lc_load_val),
    .flag_p(flag_p), .flag_z(flag_z), .lc_value(lc_value)
  );

  int n_vec = 0, n_bad = 0, fin_taken = 0, ship_taken = 0;
  logic [DW-1:0] exp_q[$];
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [24:0] mk(bit u, bit kind, bit r, bit i, bit s,
                                     bit fi, bit sh, bit dc, bit fo);
    logic [24:0] w = '0;
    w[24] = u; w[21] = kind; w[20] = r; w[19] = i; w[18] = s;
    w[17] = fi; w[16] = sh; w[15] = dc; w[14] = fo;
    return w;
  endfunction

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic issue(input logic [24:0] w);
    for (int k = 0; k < 100 && !instr_ready; k++) cyc(1);
    instr_valid = 1; instr_word = w;
    cyc(1);
    instr_valid = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 100 && !instr_ready; k++) cyc(1);
  endtask

  task automatic set_p(input bit v);
    set_p_en = 1; set_p_val = v; cyc(1); set_p_en = 0;
  endtask

  task automatic load_lc(input logic [LW-1:0] v);
    lc_load_en = 1; lc_load_val = v; cyc(1); lc_load_en = 0;
  endtask

  task automatic torp();
    torpedo = 1; cyc(1); torpedo = 0;
  endtask

  // Scoreboard monitor and handshake counters, sampled away from the edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (fin_valid && fin_ready) fin_taken++;
      if (ship_in_valid && ship_in_ready) ship_taken++;
      if (fout_valid && fout_ready) begin
        n_vec++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R5: got word %0h expected no word", fout_data);
        end else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          if (fout_data !== e) begin
            n_bad++;
            $display("FAIL R5/R7: got %0h expected %0h", fout_data, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R1 watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int t;
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk("R1 ready after reset", instr_ready, 1);
    chk("R1 fout empty after reset", fout_valid, 0);
    chk("R1 P after reset", flag_p, 0);
    chk("R9 Z after reset", flag_z, 1);

    // R2: predicated move discarded while P=0
    load_lc(5);
    fin_valid = 1; fin_data = 32'hA1;
    issue(mk(0,0,0,0,1,1,0,1,1));
    wait_idle(); cyc(2);
    chk("R2 discard takes no fabric word", fin_taken, 0);
    chk("R2 discard keeps LC", lc_value, 5);
    chk("R2 discard gives no output", fout_valid, 0);
    chk("R9 Z low at LC=5", flag_z, 0);

    // R2/R7: unconditional move runs with P=0, capture from fabric
    exp_q.push_back(32'hA1);
    issue(mk(1,0,0,0,0,1,0,1,1));
    wait_idle(); cyc(2);
    chk("R4 one fabric word taken", fin_taken, 1);

    // R3: non-move word discarded
    issue(mk(1,1,0,0,1,1,0,1,1));
    wait_idle(); cyc(2);
    chk("R3 no fabric word", fin_taken, 1);
    chk("R3 LC unchanged", lc_value, 5);
    chk("R3 no output", fout_valid, 0);

    // R4: fabric-in waits for valid
    fin_valid = 0;
    issue(mk(1,0,0,0,0,1,0,0,0));
    cyc(3);
    chk("R4 move waits for fabric word", instr_ready, 0);
    fin_valid = 1; fin_data = 32'h77;
    wait_idle();
    chk("R4 waiting move takes one word", fin_taken, 2);

    // R5: back-pressure on the fabric slot stalls the next move
    fout_ready = 0;
    fin_data = 32'hB1; exp_q.push_back(32'hB1);
    issue(mk(1,0,0,0,0,1,0,1,1));
    wait_idle();
    fin_data = 32'hB2; exp_q.push_back(32'hB2);
    issue(mk(1,0,0,0,0,1,0,1,1));
    cyc(4);
    chk("R5 second move stalled", instr_ready, 0);
    chk("R5 slot data held", fout_data, 32'hB1);
    chk("R5 stalled move took no word", fin_taken, 3);
    fout_ready = 1;
    wait_idle(); cyc(2);
    chk("R5 stalled move completes", fin_taken, 4);

    // R6/R7: ship word captured, latch reused
    fin_valid = 0;
    ship_in_valid = 1; ship_in_data = 32'h5151;
    exp_q.push_back(32'h5151);
    issue(mk(1,0,0,0,0,0,1,1,1));
    wait_idle(); cyc(1);
    chk("R6 one ship word taken", ship_taken, 1);
    ship_in_valid = 0;
    exp_q.push_back(32'h5151);
    issue(mk(1,0,0,0,0,0,0,0,1));
    fin_valid = 1; fin_data = 32'hC1;
    exp_q.push_back(32'h5151);
    issue(mk(1,0,0,0,0,1,0,0,1));
    wait_idle(); cyc(2);
    chk("R7 latch kept without capture", fin_taken, 5);
    fin_valid = 0;

    // R8: decrement, zero clear, floor
    load_lc(2); set_p(1);
    issue(mk(0,0,0,0,1,0,0,0,0)); wait_idle();
    chk("R8 LC 2->1", lc_value, 1);
    chk("R8 P kept at 1", flag_p, 1);
    issue(mk(0,0,0,0,1,0,0,0,0)); wait_idle();
    chk("R8 LC 1->0", lc_value, 0);
    chk("R8 P cleared at zero", flag_p, 0);
    chk("R9 Z high at zero", flag_z, 1);
    set_p(1);
    issue(mk(1,0,0,0,1,0,0,0,0)); wait_idle(); cyc(1);
    chk("R8 LC floor", lc_value, 0);
    chk("R8 P kept on floor decrement", flag_p, 1);

    // R10: predicated repeat stops when P drops
    load_lc(3);
    issue(mk(0,0,1,0,1,0,0,0,0)); wait_idle();
    chk("R10 repeat ran LC to zero", lc_value, 0);
    chk("R10 repeat cleared P", flag_p, 0);
    load_lc(2); set_p(1);
    exp_q.push_back(32'h5151); exp_q.push_back(32'h5151);
    issue(mk(0,0,1,0,1,0,0,0,1)); wait_idle(); cyc(2);
    chk("R10 repeat with output stops", lc_value, 0);

    // R10/R11: standing move removed by torpedo
    set_p(1);
    issue(mk(1,0,1,0,0,0,0,0,0));
    cyc(5);
    chk("R10 standing move still held", instr_ready, 0);
    torp(); wait_idle();
    chk("R11 torpedo removed standing move", instr_ready, 1);
    chk("R11 torpedo cleared P", flag_p, 0);

    // R11: immune move ignores torpedo; next move absorbs it
    set_p(1);
    issue(mk(1,0,0,1,0,1,0,0,0));
    torp(); cyc(3);
    chk("R11 immune move still waiting", instr_ready, 0);
    chk("R11 P kept with immune move", flag_p, 1);
    t = fin_taken;
    fin_valid = 1;
    wait_idle();
    chk("R11 immune move completes", fin_taken, t + 1);
    fin_valid = 0;
    issue(mk(1,0,0,0,0,1,0,0,0)); wait_idle();
    chk("R11 pending torpedo kills next move", fin_taken, t + 1);
    chk("R11 kill cleared P", flag_p, 0);
    fin_valid = 1;
    issue(mk(1,0,0,0,0,1,0,0,0)); wait_idle(); cyc(1);
    chk("R11 torpedo consumed", fin_taken, t + 2);
    fin_valid = 0;

    // R12: set_p beats zero clear, lc_load beats decrement
    set_p_en = 1; set_p_val = 1;
    load_lc(3);
    issue(mk(1,0,1,0,1,0,0,0,0));
    cyc(6);
    chk("R12 LC reached zero", lc_value, 0);
    chk("R12 set_p wins over zero clear", flag_p, 1);
    lc_load_en = 1; lc_load_val = 7;
    cyc(3);
    chk("R12 load wins over decrement", lc_value, 7);
    lc_load_en = 0; set_p_en = 0;
    torp(); wait_idle();
    chk("R11 kill after release clears P", flag_p, 0);

    cyc(5);
    chk("R5 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule